// File: doc/BRIEF.md
# Flash Read-Path Mode Multiplexer

This block is the read side of a parallel NOR flash command engine. A separate command sequencer decides which read mode is in force. This block then picks the data word that a read should return.

- In array mode it passes the storage word through unchanged.
- In identifier mode it returns one of four identifier words, or a protection flag of zero. It falls back to array data at offsets that are unused or not populated.
- In status mode it returns an operation status byte. Bit 6 of that byte flips after every accepted read strobe.
- In query mode it returns an entry from an external capability table, or zero for offsets past the table's last index.

The block also owns the status byte and the erase busy timer. A program-complete pulse loads the status byte from the written data's top bit. An erase start clears the status byte and starts a countdown, which is longer for a whole-chip erase than for a sector erase. When the countdown runs out, status bit 7 inverts and a one-cycle completion pulse goes back to the sequencer.

The read offset is a byte offset. Only its low eight bits are decoded, after they are scaled down to device words. The scaled index also drives the query table lookup port.

Top module: `flash_rdmux`

## Requirements
- R1: The decode index equals bits [7:0] of `rd_off` shifted right by log2(DEV_BYTES) (1, 2 or 4 bytes per word). Offset bits above bit 7 have no effect. The index is driven on `qry_index` in every mode.
- R2: Mode codes are 0 array, 1 erase-prefix, 2 identifier, 3 status and 4 query. Codes 0, 1, 5, 6 and 7 return `array_data` on `rd_data`.
- R3: In identifier mode, index 0 returns `ident0`, index 1 returns `ident1`, and index 2 returns zero (no sector protected).
- R4: In identifier mode, index 0x0E returns `ident2` and index 0x0F returns `ident3`. Either falls back to `array_data` when that identifier word equals 16'h00FF. Every other index returns `array_data`.
- R5: In status mode `rd_data` shows the status byte, zero-extended. Each cycle with `rd_stb` high in status mode inverts status bit 6 at the next clock edge. Cycles without the strobe leave the status byte unchanged.
- R6: A `pgm_done` pulse sets the status byte to {~pgm_msb, 7'h7F}.
- R7: A `sect_start` or `chip_start` pulse clears the status byte to 8'h00 and starts the erase timer. The timer lasts SECT_CYC cycles for a sector and SECT_CYC*CHIP_MULT cycles for the whole chip. A start pulse arriving while the timer runs restarts it.
- R8: `erase_done` goes high for exactly one cycle, N clock edges after the edge that captured the start pulse (N is the duration from R7). On the same edge status bit 7 inverts.
- R9: In query mode, an index greater than QRY_LEN returns zero. Any other index returns `qry_entry`, zero-extended.
- R10: After reset the status byte is 8'h00, `erase_done` is low and no erase is timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Read mode from the command sequencer |
| rd_stb | input | 1 | Read strobe (an accepted read) |
| rd_off | input | OFF_W | Byte offset of the read |
| array_data | input | 8*DEV_BYTES | Storage word at the read offset |
| ident0 | input | 16 | Identifier word 0 |
| ident1 | input | 16 | Identifier word 1 |
| ident2 | input | 16 | Identifier word 2 (16'h00FF = absent) |
| ident3 | input | 16 | Identifier word 3 (16'h00FF = absent) |
| pgm_done | input | 1 | Program-complete pulse |
| pgm_msb | input | 1 | Bit 7 of the programmed data |
| sect_start | input | 1 | Sector erase start pulse |
| chip_start | input | 1 | Chip erase start pulse |
| qry_index | output | 8 | Scaled index into the query table |
| qry_entry | input | 8 | Query table entry at `qry_index` |
| rd_data | output | 8*DEV_BYTES | Read data |
| erase_done | output | 1 | One-cycle erase completion pulse |

## Verification
The assertions assume the following about the sequencer:

- It never raises `pgm_done` together with an erase start.
- It holds `mode` steady while it strobes a read.

The status-bit properties exclude the cycles where two status events meet, because priority decides the outcome there rather than the flip being checked.

The stimulus keeps within these assumptions:

- Every input changes only on the falling clock edge.
- Program and erase pulses are one cycle wide and each is issued on its own.
- Status reads are issued only after an erase has completed, or between erases.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;

   typedef enum logic [2:0] {
      MD_ARRAY   = 3'd0,
      MD_PREFIX  = 3'd1,
      MD_AUTOSEL = 3'd2,
      MD_STATUS  = 3'd3,
      MD_QUERY   = 3'd4
   } rd_mode_e;

   localparam logic [15:0] ID_ABSENT  = 16'h00FF;
   localparam logic [7:0]  IDX_ID0    = 8'h00;
   localparam logic [7:0]  IDX_ID1    = 8'h01;
   localparam logic [7:0]  IDX_PROT   = 8'h02;
   localparam logic [7:0]  IDX_ID2    = 8'h0E;
   localparam logic [7:0]  IDX_ID3    = 8'h0F;

endpackage

// File: rtl/flash_rdmux_offdec.sv
module flash_rdmux_offdec #(
   parameter int OFF_W     = 12,
   parameter int DEV_BYTES = 2
) (
   input  logic [OFF_W-1:0] rd_off,
   output logic [7:0]       idx
);
   // only the low byte of the offset takes part in decode
   logic [7:0] low_byte;
   assign low_byte = rd_off[7:0];

   generate
      if (DEV_BYTES == 1) begin : g_w8
         assign idx = low_byte;
      end else if (DEV_BYTES == 2) begin : g_w16
         assign idx = {1'b0, low_byte[7:1]};
      end else begin : g_w32
         assign idx = {2'b00, low_byte[7:2]};
      end
   endgenerate
endmodule

// File: rtl/flash_rdmux_status.sv
module flash_rdmux_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_toggle,
   input  logic       pgm_stb,
   input  logic       pgm_msb,
   input  logic       erase_go,
   input  logic       expire,
   output logic [7:0] status_q
);
   logic [7:0] status_d;

   // priority: erase start, then program result, then flips
   always_comb begin
      status_d = status_q;
      if (erase_go) begin
         status_d = 8'h00;
      end else if (pgm_stb) begin
         status_d = {~pgm_msb, 7'h7F};
      end else begin
         if (expire)    status_d[7] = ~status_q[7];
         if (rd_toggle) status_d[6] = ~status_q[6];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 8'h00;
      else        status_q <= status_d;
   end
endmodule

// File: rtl/flash_rdmux_timer.sv
module flash_rdmux_timer #(
   parameter int SECT_CYC  = 50,
   parameter int CHIP_MULT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_sect,
   input  logic start_chip,
   output logic busy,
   output logic expire,
   output logic done_q
);
   localparam int CHIP_CYC = SECT_CYC * CHIP_MULT;
   localparam int CNT_W    = $clog2(CHIP_CYC + 1);
   localparam logic [CNT_W-1:0] SECT_LOAD = CNT_W'(SECT_CYC - 1);
   localparam logic [CNT_W-1:0] CHIP_LOAD = CNT_W'(CHIP_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             any_start;

   assign any_start = start_sect | start_chip;
   assign expire    = busy && (cnt_q == '0) && !any_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= expire;
         if (start_chip) begin
            cnt_q <= CHIP_LOAD;
            busy  <= 1'b1;
         end else if (start_sect) begin
            cnt_q <= SECT_LOAD;
            busy  <= 1'b1;
         end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
   import flash_rdmux_pkg::*;
#(
   parameter int OFF_W     = 12,
   parameter int DEV_BYTES = 2,
   parameter int SECT_CYC  = 50,
   parameter int CHIP_MULT = 10,
   parameter int QRY_LEN   = 8'h52,
   localparam int DATA_W   = 8 * DEV_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              rd_stb,
   input  logic [OFF_W-1:0]  rd_off,
   input  logic [DATA_W-1:0] array_data,
   input  logic [15:0]       ident0,
   input  logic [15:0]       ident1,
   input  logic [15:0]       ident2,
   input  logic [15:0]       ident3,
   input  logic              pgm_done,
   input  logic              pgm_msb,
   input  logic              sect_start,
   input  logic              chip_start,
   output logic [7:0]        qry_index,
   input  logic [7:0]        qry_entry,
   output logic [DATA_W-1:0] rd_data,
   output logic              erase_done
);
   // elaboration-time parameter checks
   generate
      if (DEV_BYTES != 1 && DEV_BYTES != 2 && DEV_BYTES != 4) begin : g_bad_width
         $error("flash_rdmux: DEV_BYTES must be 1, 2 or 4");
      end
      if (OFF_W < 8) begin : g_bad_off
         $error("flash_rdmux: OFF_W must be at least 8");
      end
      if (SECT_CYC < 1 || CHIP_MULT < 1) begin : g_bad_time
         $error("flash_rdmux: erase durations must be positive");
      end
      if (QRY_LEN < 0 || QRY_LEN > 255) begin : g_bad_qry
         $error("flash_rdmux: QRY_LEN must fit the 8-bit index");
      end
   endgenerate

   logic [7:0] idx;
   logic [7:0] status_q;
   logic       erase_busy;
   logic       erase_expire;
   logic       rd_toggle;

   flash_rdmux_offdec #(
      .OFF_W     (OFF_W),
      .DEV_BYTES (DEV_BYTES)
   ) u_offdec (
      .rd_off (rd_off),
      .idx    (idx)
   );

   assign qry_index = idx;
   assign rd_toggle = rd_stb && (mode == MD_STATUS);

   flash_rdmux_timer #(
      .SECT_CYC  (SECT_CYC),
      .CHIP_MULT (CHIP_MULT)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_sect (sect_start),
      .start_chip (chip_start),
      .busy       (erase_busy),
      .expire     (erase_expire),
      .done_q     (erase_done)
   );

   flash_rdmux_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_toggle (rd_toggle),
      .pgm_stb   (pgm_done),
      .pgm_msb   (pgm_msb),
      .erase_go  (sect_start | chip_start),
      .expire    (erase_expire),
      .status_q  (status_q)
   );

   // identifier view
   logic [DATA_W-1:0] id_word;
   always_comb begin
      case (idx)
         IDX_ID0:  id_word = DATA_W'(ident0);
         IDX_ID1:  id_word = DATA_W'(ident1);
         IDX_PROT: id_word = '0;
         IDX_ID2:  id_word = (ident2 == ID_ABSENT) ? array_data : DATA_W'(ident2);
         IDX_ID3:  id_word = (ident3 == ID_ABSENT) ? array_data : DATA_W'(ident3);
         default:  id_word = array_data;
      endcase
   end

   // query view
   logic [DATA_W-1:0] qry_word;
   assign qry_word = (32'(idx) > QRY_LEN) ? '0 : DATA_W'(qry_entry);

   always_comb begin
      case (rd_mode_e'(mode))
         MD_AUTOSEL: rd_data = id_word;
         MD_STATUS:  rd_data = DATA_W'(status_q);
         MD_QUERY:   rd_data = qry_word;
         default:    rd_data = array_data;
      endcase
   end

   logic unused_busy;
   assign unused_busy = erase_busy;
endmodule

// File: rtl/flash_rdmux_chk.sv
module flash_rdmux_chk #(
   parameter int DATA_W  = 16,
   parameter int QRY_LEN = 8'h52
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              rd_stb,
   input logic              pgm_done,
   input logic              pgm_msb,
   input logic              sect_start,
   input logic              chip_start,
   input logic              expire,
   input logic              erase_done,
   input logic [7:0]        qry_index,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] array_data,
   input logic [7:0]        status_q
);
   // R5
   status_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == 3'd3 && !pgm_done && !sect_start && !chip_start && !expire)
      |=> (status_q[6] != $past(status_q[6])));

   // R7
   erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_start || chip_start) |=> (status_q == 8'h00));

   // R6
   pgm_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_done && !sect_start && !chip_start)
      |=> (status_q == {~$past(pgm_msb), 7'h7F}));

   // R8
   done_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_done && !$past(pgm_done) && !$past(sect_start) && !$past(chip_start))
      |-> (status_q[7] != $past(status_q[7])));

   // R9
   qry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && 32'(qry_index) > QRY_LEN) |-> (rd_data == '0));

   // R3
   prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2 && qry_index == 8'h02) |-> (rd_data == '0));

   // R2
   array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || mode == 3'd1) |-> (rd_data == array_data));
endmodule

bind flash_rdmux flash_rdmux_chk #(
   .DATA_W  (DATA_W),
   .QRY_LEN (QRY_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .rd_stb     (rd_stb),
   .pgm_done   (pgm_done),
   .pgm_msb    (pgm_msb),
   .sect_start (sect_start),
   .chip_start (chip_start),
   .expire     (erase_expire),
   .erase_done (erase_done),
   .qry_index  (qry_index),
   .rd_data    (rd_data),
   .array_data (array_data),
   .status_q   (status_q)
);

// File: tb/flash_rdmux_bench.sv
`timescale 1ns/1ps
module flash_rdmux_bench;
   localparam int SECT = 20;
   localparam int MULT = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        rd_stb = 1'b0;
   logic [11:0] rd_off = '0;
   logic [15:0] array_data = 16'hA5C3;
   logic [15:0] ident0 = 16'h0001, ident1 = 16'h227E;
   logic [15:0] ident2 = 16'h2222, ident3 = 16'h00FF;
   logic        pgm_done = 1'b0, pgm_msb = 1'b0;
   logic        sect_start = 1'b0, chip_start = 1'b0;
   logic [7:0]  qry_index;
   logic [7:0]  qry_entry;
   logic [15:0] rd_data;
   logic        erase_done;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   event        sample_ev;

   always #2 clk = ~clk;
   assign qry_entry = qry_index ^ 8'h5A;

   flash_rdmux #(.SECT_CYC(SECT), .CHIP_MULT(MULT)) u_flash_rdmux (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rd_stb(rd_stb), .rd_off(rd_off),
      .array_data(array_data), .ident0(ident0), .ident1(ident1),
      .ident2(ident2), .ident3(ident3), .pgm_done(pgm_done), .pgm_msb(pgm_msb),
      .sect_start(sect_start), .chip_start(chip_start), .qry_index(qry_index),
      .qry_entry(qry_entry), .rd_data(rd_data), .erase_done(erase_done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read words and compares
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() != 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {16'h0, rd_data}, {16'h0, e});
         end
      end
   end

   // driver: one read per cycle, expected value queued
   task automatic rd(input logic [2:0] md, input logic [11:0] off, input logic stb,
                     input logic [15:0] exp, input string tag);
      @(negedge clk);
      mode = md; rd_off = off; rd_stb = stb;
      #1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      -> sample_ev;
      @(posedge clk);
      #1 rd_stb = 1'b0;
   endtask

   task automatic pgm(input logic msb);
      @(negedge clk); pgm_done = 1'b1; pgm_msb = msb;
      @(negedge clk); pgm_done = 1'b0;
   endtask

   task automatic erase_run(input logic chip, input int n_exp, input string tag);
      int n;
      @(negedge clk);
      if (chip) chip_start = 1'b1; else sect_start = 1'b1;
      @(posedge clk);
      #1 chip_start = 1'b0; sect_start = 1'b0; mode = 3'd3; rd_stb = 1'b0;
      #1 check({tag, " R7 cleared"}, {16'h0, rd_data}, 32'h0);
      n = 0;
      while (n < 5000) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (erase_done) break;
      end
      check({tag, " R7/R8 duration"}, n, n_exp);
      @(negedge clk);
      check({tag, " R8 single pulse"}, {31'h0, erase_done}, 32'h0);
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R10 reset state
      rd(3'd3, 12'h0, 1'b0, 16'h0000, "R10 status after reset");
      check("R10 erase_done after reset", {31'h0, erase_done}, 32'h0);
      // R2 array passthrough
      rd(3'd0, 12'h0, 1'b0, 16'hA5C3, "R2 array mode");
      rd(3'd1, 12'h33, 1'b0, 16'hA5C3, "R2 erase-prefix mode");
      rd(3'd7, 12'h04, 1'b0, 16'hA5C3, "R2 unused code");
      // R1 index scaling and high-bit masking
      @(negedge clk); mode = 3'd4; rd_off = 12'h004; #1;
      check("R1 index of 0x004", {24'h0, qry_index}, 32'h02);
      rd_off = 12'h1FE; #1;
      check("R1 index of 0x1FE", {24'h0, qry_index}, 32'h7F);
      // R3/R4 identifier mode (16-bit: byte offset = index*2)
      rd(3'd2, 12'h000, 1'b0, 16'h0001, "R3 ident0");
      rd(3'd2, 12'h002, 1'b0, 16'h227E, "R3 ident1");
      rd(3'd2, 12'h004, 1'b0, 16'h0000, "R3 protection");
      rd(3'd2, 12'h01C, 1'b0, 16'h2222, "R4 ident2");
      rd(3'd2, 12'h01E, 1'b0, 16'hA5C3, "R4 ident3 absent");
      rd(3'd2, 12'h010, 1'b0, 16'hA5C3, "R4 undefined index");
      ident3 = 16'h1234;
      rd(3'd2, 12'h01E, 1'b0, 16'h1234, "R4 ident3 present");
      // R5 toggle on strobe only
      rd(3'd3, 12'h0, 1'b1, 16'h0000, "R5 first status read");
      rd(3'd3, 12'h0, 1'b1, 16'h0040, "R5 toggled");
      rd(3'd3, 12'h0, 1'b0, 16'h0000, "R5 toggled back");
      rd(3'd3, 12'h0, 1'b0, 16'h0000, "R5 no strobe no toggle");
      // R6 program completion
      pgm(1'b1);
      rd(3'd3, 12'h0, 1'b1, 16'h007F, "R6 msb=1");
      rd(3'd3, 12'h0, 1'b0, 16'h003F, "R5 toggle after program");
      pgm(1'b0);
      rd(3'd3, 12'h0, 1'b0, 16'h00FF, "R6 msb=0");
      // R7/R8 erase timing
      erase_run(1'b0, SECT, "sector");
      rd(3'd3, 12'h0, 1'b1, 16'h0080, "R8 bit7 after sector");
      erase_run(1'b1, SECT * MULT, "chip");
      rd(3'd3, 12'h0, 1'b0, 16'h0080, "R8 bit7 after chip");
      // R9 query table
      rd(3'd4, 12'h020, 1'b0, 16'h004A, "R9 entry 0x10");
      rd(3'd4, 12'h0A4, 1'b0, 16'h0008, "R9 last index");
      rd(3'd4, 12'h0A6, 1'b0, 16'h0000, "R9 beyond table");
      rd(3'd4, 12'h0FE, 1'b0, 16'h0000, "R9 top index");
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule